// File: doc/BRIEF.md
# USB Bus Suspend and Resume Monitor

This block watches the synchronized D+ and D- samples of a full-speed USB port and tells firmware when the bus has gone quiet long enough to count as suspended, and when traffic or resume signalling shows up again. A saturating counter measures how long the line has stayed in the idle J state without a break. When that run reaches a threshold set by a parameter, the suspend flag is raised. Any fresh departure from idle raises the wakeup flag.

The two flags are independent status bits, but they exclude each other in hardware. Raising one drops the other on the same clock edge. Wakeup does not depend on being suspended. Firmware clears each flag with a one-cycle strobe. A single interrupt request line combines the two flags, each gated by its own enable.

While the clock-freeze control is asserted, the idle counter holds its value. Activity detection keeps running during that time, so a resume can still be seen. Dropping the controller enable, or applying reset, returns the block to its empty state.

Top module: `usb_suspend_wake`

## Requirements
- R1: The line counts as idle (J) only when D+ is 1 and D- is 0. The suspend flag goes to 1 on the clock edge that samples the IDLE_CYCLES-th idle sample in a row, and not one edge earlier.
- R2: Within one unbroken idle run the suspend flag is raised at most once. After firmware clears it, continued idle does not raise it again.
- R3: The wakeup flag goes to 1 on the edge that samples the first non-idle value after an idle sample, whether or not the suspend flag is set. Later non-idle samples that follow a non-idle sample do not raise it again.
- R4: When the wakeup flag is raised, the suspend flag goes to 0 on the same edge.
- R5: When the suspend flag is raised, the wakeup flag goes to 0 on the same edge.
- R6: irqReq is 1 exactly when (suspFlag and suspIe) or (wakeFlag and wakeIe). With both enables at 0 it stays 0.
- R7: While clkFreeze is 1 the idle count holds its value, and resumes from that value once clkFreeze returns to 0. Wakeup detection keeps working while clkFreeze is 1.
- R8: A one-cycle suspClr or wakeClr pulse clears its flag on the next edge. If a hardware set of that flag lands in the same cycle, the set wins.
- R9: An active-low reset, or a cycle with ctrlEn at 0, clears both flags, the idle count and the activity history. No flag can be set while ctrlEn is 0.
- R10: Any non-idle sample (K, SE0, or both lines high) restarts the idle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dpIn | input | 1 | Synchronized D+ sample |
| dmIn | input | 1 | Synchronized D- sample |
| ctrlEn | input | 1 | Controller enable; 0 holds the block cleared |
| clkFreeze | input | 1 | Freezes the idle counter while 1 |
| suspIe | input | 1 | Interrupt enable for the suspend flag |
| wakeIe | input | 1 | Interrupt enable for the wakeup flag |
| suspClr | input | 1 | One-cycle clear strobe for the suspend flag |
| wakeClr | input | 1 | One-cycle clear strobe for the wakeup flag |
| suspFlag | output | 1 | Bus suspend detected |
| wakeFlag | output | 1 | Bus activity detected after idle |
| irqReq | output | 1 | Combined, enable-gated interrupt request |

## Verification
The bound checker watches, on every cycle, that the two flags are never both set, that interrupt gating holds, and that a disable cycle empties both flags. It also confirms that every activity edge raises wakeup and that an uncontested clear takes effect. The checker keeps its own idle-run counter, so it can also confirm that suspend only rises once a full, unfrozen idle run has reached the threshold. Several behaviours need a planned stimulus sequence and only the directed scenarios show them: the exact edge on which suspend appears, no second suspend within one idle run, the counter resuming after a freeze, set winning over clear, and the count restarting on SE0 or on both lines high.

// File: rtl/usb_sw_pkg.sv
package usb_sw_pkg;

  // Strobes issued by the control half to the datapath half each cycle.
  typedef struct packed {
    logic flush;     // controller disabled: empty everything
    logic cntClear;  // non-idle sample: restart the idle run
    logic cntRun;    // idle, not frozen, not saturated: advance
    logic setSusp;   // idle run reaches the threshold this cycle
    logic setWake;   // first non-idle sample after an idle one
    logic clrSusp;   // firmware clear of the suspend flag
    logic clrWake;   // firmware clear of the wakeup flag
  } swStrobe_t;

  function automatic logic isIdleJ(input logic dp, input logic dm);
    return dp && !dm;
  endfunction

endpackage

// File: rtl/usb_sw_ctrl.sv
module usb_sw_ctrl
  import usb_sw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dpIn,
  input  logic       dmIn,
  input  logic       ctrlEn,
  input  logic       clkFreeze,
  input  logic       suspClr,
  input  logic       wakeClr,
  input  logic       cntNear,
  input  logic       cntFull,
  output swStrobe_t  strobe
);

  logic lineIdle;
  logic prevIdle;

  assign lineIdle = isIdleJ(dpIn, dmIn);

  // Activity history keeps running under clock freeze so resume is seen.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        prevIdle <= 1'b0;
    else if (!ctrlEn) prevIdle <= 1'b0;
    else              prevIdle <= lineIdle;
  end

  always_comb begin
    strobe          = '0;
    strobe.flush    = !ctrlEn;
    strobe.cntClear = ctrlEn && !lineIdle;
    strobe.cntRun   = ctrlEn && lineIdle && !clkFreeze && !cntFull;
    strobe.setSusp  = strobe.cntRun && cntNear;
    strobe.setWake  = ctrlEn && prevIdle && !lineIdle;
    strobe.clrSusp  = ctrlEn && suspClr;
    strobe.clrWake  = ctrlEn && wakeClr;
  end

endmodule

// File: rtl/usb_sw_dp.sv
module usb_sw_dp
  import usb_sw_pkg::*;
#(
  parameter int IDLE_CYCLES = 36000
) (
  input  logic       clk,
  input  logic       rstN,
  input  swStrobe_t  strobe,
  input  logic       suspIe,
  input  logic       wakeIe,
  output logic       cntNear,
  output logic       cntFull,
  output logic       suspFlag,
  output logic       wakeFlag,
  output logic       irqReq
);

  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT     = CNT_W'(IDLE_CYCLES);
  localparam logic [CNT_W-1:0] LIMIT_M1  = CNT_W'(IDLE_CYCLES - 1);

  logic [CNT_W-1:0] idleCnt;

  assign cntNear = (idleCnt == LIMIT_M1);
  assign cntFull = (idleCnt == LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                idleCnt <= '0;
    else if (strobe.flush || strobe.cntClear) idleCnt <= '0;
    else if (strobe.cntRun)                   idleCnt <= idleCnt + 1'b1;
  end

  // Set wins over both the firmware clear and the cross-clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 suspFlag <= 1'b0;
    else if (strobe.flush)                     suspFlag <= 1'b0;
    else if (strobe.setSusp)                   suspFlag <= 1'b1;
    else if (strobe.setWake || strobe.clrSusp) suspFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 wakeFlag <= 1'b0;
    else if (strobe.flush)                     wakeFlag <= 1'b0;
    else if (strobe.setWake)                   wakeFlag <= 1'b1;
    else if (strobe.setSusp || strobe.clrWake) wakeFlag <= 1'b0;
  end

  assign irqReq = (suspFlag && suspIe) || (wakeFlag && wakeIe);

endmodule

// File: rtl/usb_suspend_wake.sv
module usb_suspend_wake
  import usb_sw_pkg::*;
#(
  parameter int IDLE_CYCLES = 36000
) (
  input  logic clk,
  input  logic rstN,
  input  logic dpIn,
  input  logic dmIn,
  input  logic ctrlEn,
  input  logic clkFreeze,
  input  logic suspIe,
  input  logic wakeIe,
  input  logic suspClr,
  input  logic wakeClr,
  output logic suspFlag,
  output logic wakeFlag,
  output logic irqReq
);

  swStrobe_t strobe;
  logic      cntNear;
  logic      cntFull;

  usb_sw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dpIn      (dpIn),
    .dmIn      (dmIn),
    .ctrlEn    (ctrlEn),
    .clkFreeze (clkFreeze),
    .suspClr   (suspClr),
    .wakeClr   (wakeClr),
    .cntNear   (cntNear),
    .cntFull   (cntFull),
    .strobe    (strobe)
  );

  usb_sw_dp #(.IDLE_CYCLES(IDLE_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .suspIe   (suspIe),
    .wakeIe   (wakeIe),
    .cntNear  (cntNear),
    .cntFull  (cntFull),
    .suspFlag (suspFlag),
    .wakeFlag (wakeFlag),
    .irqReq   (irqReq)
  );

endmodule

// File: rtl/usb_sw_checker.sv
module usb_sw_checker #(
  parameter int IDLE_CYCLES = 36000
) (
  input logic clk,
  input logic rstN,
  input logic dpIn,
  input logic dmIn,
  input logic ctrlEn,
  input logic clkFreeze,
  input logic suspIe,
  input logic wakeIe,
  input logic suspClr,
  input logic wakeClr,
  input logic suspFlag,
  input logic wakeFlag,
  input logic irqReq
);

  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

  logic             idleNow;
  logic             prevIdleC;
  logic [CNT_W-1:0] idleRun;
  logic             activity;

  assign idleNow  = dpIn && !dmIn;
  assign activity = ctrlEn && prevIdleC && !idleNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIdleC <= 1'b0;
      idleRun   <= '0;
    end else if (!ctrlEn) begin
      prevIdleC <= 1'b0;
      idleRun   <= '0;
    end else begin
      prevIdleC <= idleNow;
      if (!idleNow)                       idleRun <= '0;
      else if (!clkFreeze && idleRun != LIMIT) idleRun <= idleRun + 1'b1;
    end
  end

  // R4, R5: the flags exclude each other
  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(suspFlag && wakeFlag));

  // R6: no request without an enable
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!suspIe && !wakeIe) |-> !irqReq);

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (suspFlag || wakeFlag));

  // R9: a disabled cycle empties both flags
  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> (!suspFlag && !wakeFlag));

  // R3: activity after idle raises wakeup
  p_wake_on_activity_r3: assert property (@(posedge clk) disable iff (!rstN)
    activity |=> wakeFlag);

  // R1, R7: suspend only after a full unfrozen idle run
  p_susp_after_run_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspFlag) |-> (idleRun == LIMIT));

  // R8: an uncontested clear takes effect
  p_wake_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wakeClr && ctrlEn && !activity) |=> !wakeFlag);

endmodule

bind usb_suspend_wake usb_sw_checker #(.IDLE_CYCLES(IDLE_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dpIn      (dpIn),
  .dmIn      (dmIn),
  .ctrlEn    (ctrlEn),
  .clkFreeze (clkFreeze),
  .suspIe    (suspIe),
  .wakeIe    (wakeIe),
  .suspClr   (suspClr),
  .wakeClr   (wakeClr),
  .suspFlag  (suspFlag),
  .wakeFlag  (wakeFlag),
  .irqReq    (irqReq)
);

// File: tb/test_usb_suspend_wake.sv
`timescale 1ns/1ps
module test_usb_suspend_wake;

  localparam int N = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dpIn = 1'b1, dmIn = 1'b0;
  logic ctrlEn = 1'b0, clkFreeze = 1'b0;
  logic suspIe = 1'b0, wakeIe = 1'b0;
  logic suspClr = 1'b0, wakeClr = 1'b0;
  logic suspFlag, wakeFlag, irqReq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  usb_suspend_wake #(.IDLE_CYCLES(N)) i_usb_suspend_wake (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn), .ctrlEn(ctrlEn),
    .clkFreeze(clkFreeze), .suspIe(suspIe), .wakeIe(wakeIe),
    .suspClr(suspClr), .wakeClr(wakeClr),
    .suspFlag(suspFlag), .wakeFlag(wakeFlag), .irqReq(irqReq)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one line sample, let one edge take it, settle just after the edge.
  task automatic cyc(input logic dp, input logic dm);
    dpIn = dp; dmIn = dm;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  task automatic restart();
    ctrlEn = 1'b0; cyc(1'b1, 1'b0); ctrlEn = 1'b1;
  endtask

  task automatic tReset();
    check("R9", "susp after reset", suspFlag, 1'b0);
    check("R9", "wake after reset", wakeFlag, 1'b0);
    check("R9", "irq after reset", irqReq, 1'b0);
  endtask

  task automatic tSuspend();
    restart(); suspIe = 1'b1;
    idle(N - 1);
    check("R1", "susp one short", suspFlag, 1'b0);
    check("R6", "irq one short", irqReq, 1'b0);
    idle(1);
    check("R1", "susp at threshold", suspFlag, 1'b1);
    check("R6", "irq with suspIe", irqReq, 1'b1);
    suspIe = 1'b0; #1;
    check("R6", "irq gated off", irqReq, 1'b0);
    suspClr = 1'b1; idle(1); suspClr = 1'b0;
    check("R8", "susp cleared", suspFlag, 1'b0);
    idle(3 * N);
    check("R2", "no second suspend", suspFlag, 1'b0);
  endtask

  task automatic tWake();
    restart();
    idle(3);
    cyc(1'b0, 1'b1);
    check("R3", "wake on K not suspended", wakeFlag, 1'b1);
    check("R3", "susp stays low", suspFlag, 1'b0);
    wakeIe = 1'b1; #1;
    check("R6", "irq with wakeIe", irqReq, 1'b1);
    wakeIe = 1'b0; #1;
    check("R6", "irq wake gated", irqReq, 1'b0);
    wakeClr = 1'b1; cyc(1'b0, 1'b1); wakeClr = 1'b0;
    check("R8", "wake cleared", wakeFlag, 1'b0);
    for (int i = 0; i < 4; i++) begin cyc(1'b0, 1'b0); cyc(1'b0, 1'b1); end
    check("R3", "no re-raise in traffic", wakeFlag, 1'b0);
    cyc(1'b1, 1'b0); cyc(1'b0, 1'b1);
    check("R3", "wake after new idle", wakeFlag, 1'b1);
  endtask

  task automatic tCross();
    restart();
    idle(N);
    check("R1", "susp set", suspFlag, 1'b1);
    cyc(1'b0, 1'b1);
    check("R4", "wake raised", wakeFlag, 1'b1);
    check("R4", "susp dropped", suspFlag, 1'b0);
    idle(N - 1);
    check("R5", "wake held before threshold", wakeFlag, 1'b1);
    idle(1);
    check("R5", "susp raised", suspFlag, 1'b1);
    check("R5", "wake dropped", wakeFlag, 1'b0);
  endtask

  task automatic tRestartCount();
    restart();
    idle(N - 5); cyc(1'b0, 1'b0);
    idle(N - 1);
    check("R10", "SE0 restarts count", suspFlag, 1'b0);
    idle(1);
    check("R10", "full run after SE0", suspFlag, 1'b1);
    restart();
    idle(N - 5); cyc(1'b1, 1'b1);
    idle(N - 1);
    check("R10", "both-high restarts count", suspFlag, 1'b0);
    check("R10", "both-high counts as activity", wakeFlag, 1'b1);
  endtask

  task automatic tFreeze();
    restart();
    idle(10);
    clkFreeze = 1'b1; idle(3 * N);
    check("R7", "no suspend while frozen", suspFlag, 1'b0);
    clkFreeze = 1'b0; idle(N - 11);
    check("R7", "count held through freeze", suspFlag, 1'b0);
    idle(1);
    check("R7", "count resumed", suspFlag, 1'b1);
    clkFreeze = 1'b1; cyc(1'b0, 1'b1);
    check("R7", "wake while frozen", wakeFlag, 1'b1);
    check("R4", "susp dropped while frozen", suspFlag, 1'b0);
    clkFreeze = 1'b0;
  endtask

  task automatic tSetWins();
    restart();
    idle(N - 1);
    suspClr = 1'b1; idle(1); suspClr = 1'b0;
    check("R8", "susp set beats clear", suspFlag, 1'b1);
    wakeClr = 1'b1; cyc(1'b0, 1'b1); wakeClr = 1'b0;
    check("R8", "wake set beats clear", wakeFlag, 1'b1);
  endtask

  task automatic tDisable();
    restart();
    idle(3); cyc(1'b0, 1'b1);
    check("R9", "wake set before disable", wakeFlag, 1'b1);
    ctrlEn = 1'b0; cyc(1'b1, 1'b0);
    check("R9", "wake cleared by disable", wakeFlag, 1'b0);
    cyc(1'b0, 1'b1); idle(2 * N); cyc(1'b0, 1'b1);
    check("R9", "no wake while disabled", wakeFlag, 1'b0);
    check("R9", "no suspend while disabled", suspFlag, 1'b0);
    ctrlEn = 1'b1;
    idle(N - 1);
    check("R9", "count restarted on enable", suspFlag, 1'b0);
    idle(1);
    check("R9", "suspend after full run", suspFlag, 1'b1);
    #1 rstN = 1'b0; #1;
    check("R9", "async reset clears susp", suspFlag, 1'b0);
    cyc(1'b1, 1'b0); rstN = 1'b1; idle(N - 1);
    check("R9", "count cleared by reset", suspFlag, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    rstN = 1'b1;
    ctrlEn = 1'b1;
    tSuspend();
    tWake();
    tCross();
    tRestartCount();
    tFreeze();
    tSetWins();
    tDisable();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule